// File: doc/BRIEF.md
# UART Automatic RTS/CTS Handshake Controller

This block sits beside the receive and transmit FIFOs of a UART (32 entries each) and runs the hardware handshake lines without software help. On the receive side it watches the receive FIFO occupancy. When the FIFO is close to full, it pulls the RTS line to its inactive level. It releases the line only after the FIFO has drained well below that point, so the line does not chatter around a single threshold. On the transmit side it synchronises the incoming CTS line. While the remote end holds CTS inactive, it refuses permission to start the next character. A character that has already started is never interrupted, because the block only gates the start request.

Each direction is switched on by its own bit of an enhanced-feature byte. With the automatic mode off, RTS follows the modem-control RTS bit and CTS has no effect. Two sticky change flags record every edge of the RTS output and of the synchronised CTS. A read strobe from the CPU clears them. Each flag can raise the interrupt line through its own bit of the interrupt-enable byte.

Top module: `uart_autoflow`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rts_n_out` is 1 (inactive), both change flags are 0, and `irq` is 0.
- R2: With `feat_reg[6]` = 1, `rts_n_out` is 1 in the cycle after a clock edge at which `rx_level` >= 28.
- R3: With `feat_reg[6]` = 1, `rts_n_out` is 0 in the cycle after an edge at which `rx_level` <= 16. For levels 17 to 27 it keeps its previous automatic value. Enabling the automatic mode starts from the released (0) state.
- R4: With `feat_reg[6]` = 0, `rts_n_out` equals the inverse of `mcr_rts` sampled at the previous clock edge. `rx_level` has no effect.
- R5: `cts_n_in` passes through two flip-flops. A change made before clock edge k is seen by `tx_go` after edge k+1.
- R6: With `feat_reg[7]` = 1, `tx_go` is 0 while the synchronised CTS is inactive (1). Otherwise `tx_go` equals `tx_start_req`.
- R7: With `feat_reg[7]` = 0, `tx_go` equals `tx_start_req` whatever the CTS level.
- R8: `tx_go` is never 1 while `tx_start_req` is 0, so a character in flight is never cut and no start is invented.
- R9: `rts_chg` (`cts_chg`) becomes 1 one edge after any change of `rts_n_out` (of the synchronised CTS). It stays 1 until an edge with `flag_rd` = 1. If a new change and the read arrive at the same edge, the flag stays set.
- R10: `irq` = (`rts_chg` and `irq_en[6]`) or (`cts_chg` and `irq_en[7]`). With both of these enable bits at 0, `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_reg | input | 8 | Enhanced-feature byte: bit 7 auto CTS, bit 6 auto RTS |
| irq_en | input | 8 | Interrupt-enable byte: bit 6 RTS change, bit 7 CTS change |
| mcr_rts | input | 1 | Manual RTS request from the modem-control register (1 = assert) |
| rx_level | input | 6 | Receive FIFO occupancy, 0 to 32 |
| cts_n_in | input | 1 | Asynchronous CTS pin, active low |
| tx_start_req | input | 1 | Transmitter wants to start a new character |
| flag_rd | input | 1 | CPU read strobe that clears the change flags |
| rts_n_out | output | 1 | RTS pin, active low |
| tx_go | output | 1 | Permission to start the requested character |
| rts_chg | output | 1 | Sticky RTS-edge flag |
| cts_chg | output | 1 | Sticky CTS-edge flag |
| irq | output | 1 | Handshake interrupt request |

## Verification
The bench targets the hysteresis band. It walks the level up through 27 and 28 and back down through 17 and 16. A design that compares against a single threshold would release RTS at 27 or 20 instead of holding it. It toggles the auto-RTS enable in the middle of the band, where a design that kept stale throttle state would leave RTS inactive. It checks the CTS latency in exact cycles, which would expose a missing or extra synchroniser stage. It also issues a read strobe in the same cycle as a fresh edge, where a clear-priority flag would lose the event. Random stretches mix all the inputs against a cycle model of these rules.

// File: rtl/autoflow_pkg.sv
package autoflow_pkg;

    localparam int unsigned AF_FIFO_DEPTH = 32;
    localparam int unsigned AF_LVL_W      = $clog2(AF_FIFO_DEPTH + 1);

    // control bit positions inside the feature and interrupt-enable bytes
    localparam int unsigned AF_FEAT_AUTO_CTS = 7;
    localparam int unsigned AF_FEAT_AUTO_RTS = 6;
    localparam int unsigned AF_IEN_RTS       = 6;
    localparam int unsigned AF_IEN_CTS       = 7;

    typedef enum logic [0:0] {
        CHG_RTS = 1'b0,
        CHG_CTS = 1'b1
    } chg_idx_e;

    typedef struct packed {
        logic cts;
        logic rts;
    } chg_flags_t;

    // Next throttle state of the receive side (1 = hold the remote off).
    function automatic logic af_throttle_next(
        input logic [AF_LVL_W-1:0] level,
        input logic                throttle,
        input int unsigned         hi_mark,
        input int unsigned         lo_mark
    );
        if (int'(level) >= int'(hi_mark))
            return 1'b1;
        else if (int'(level) <= int'(lo_mark))
            return 1'b0;
        return throttle;
    endfunction

endpackage

// File: rtl/af_sync.sv
module af_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= {STAGES{RST_VAL}};
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/af_rts_ctrl.sv
module af_rts_ctrl
    import autoflow_pkg::*;
#(
    parameter int unsigned LVL_W   = AF_LVL_W,
    parameter int unsigned HI_MARK = 28,
    parameter int unsigned LO_MARK = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_en,
    input  logic             mcr_rts,
    input  logic [LVL_W-1:0] level,
    output logic             rts_n
);
    logic throttle_q;
    logic throttle_d;

    always_comb begin
        if (auto_en)
            throttle_d = af_throttle_next(level, throttle_q, HI_MARK, LO_MARK);
        else
            throttle_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            throttle_q <= 1'b0;
            rts_n      <= 1'b1;
        end else begin
            throttle_q <= throttle_d;
            rts_n      <= auto_en ? throttle_d : ~mcr_rts;
        end
    end
endmodule

// File: rtl/af_edge_flag.sv
module af_edge_flag #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    input  logic clr,
    output logic flag
);
    logic sig_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_prev <= RST_VAL;
            flag     <= 1'b0;
        end else begin
            sig_prev <= sig;
            // a fresh edge wins over a simultaneous read
            if (sig != sig_prev)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
    import autoflow_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH  = AF_FIFO_DEPTH,
    parameter int unsigned HI_MARK     = 28,
    parameter int unsigned LO_MARK     = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       feat_reg,
    input  logic [7:0]       irq_en,
    input  logic             mcr_rts,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             cts_n_in,
    input  logic             tx_start_req,
    input  logic             flag_rd,
    output logic             rts_n_out,
    output logic             tx_go,
    output logic             rts_chg,
    output logic             cts_chg,
    output logic             irq
);
    logic       auto_rts;
    logic       auto_cts;
    logic       cts_n_sync;
    logic [1:0] watched;
    chg_flags_t flags;
    logic [1:0] flag_vec;

    assign auto_rts = feat_reg[AF_FEAT_AUTO_RTS];
    assign auto_cts = feat_reg[AF_FEAT_AUTO_CTS];

    af_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
        .clk (clk),
        .rst (rst),
        .d   (cts_n_in),
        .q   (cts_n_sync)
    );

    af_rts_ctrl #(.LVL_W(LVL_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_rts (
        .clk     (clk),
        .rst     (rst),
        .auto_en (auto_rts),
        .mcr_rts (mcr_rts),
        .level   (rx_level),
        .rts_n   (rts_n_out)
    );

    assign watched[CHG_RTS] = rts_n_out;
    assign watched[CHG_CTS] = cts_n_sync;

    for (genvar g = 0; g < 2; g++) begin : g_flag
        af_edge_flag #(.RST_VAL(1'b1)) u_flag (
            .clk  (clk),
            .rst  (rst),
            .sig  (watched[g]),
            .clr  (flag_rd),
            .flag (flag_vec[g])
        );
    end

    assign flags.rts = flag_vec[CHG_RTS];
    assign flags.cts = flag_vec[CHG_CTS];

    assign tx_go   = tx_start_req & (~auto_cts | ~cts_n_sync);
    assign rts_chg = flags.rts;
    assign cts_chg = flags.cts;
    assign irq     = (flags.rts & irq_en[AF_IEN_RTS]) | (flags.cts & irq_en[AF_IEN_CTS]);
endmodule

// File: rtl/uart_autoflow_checker.sv
module uart_autoflow_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] feat_reg,
    input logic [7:0] irq_en,
    input logic       mcr_rts,
    input logic [5:0] rx_level,
    input logic       tx_start_req,
    input logic       rts_n_out,
    input logic       tx_go,
    input logic       rts_chg,
    input logic       irq
);
    assert_rts_high_mark_R2: assert property (@(posedge clk) disable iff (rst)
        (feat_reg[6] && rx_level >= 6'd28) |=> rts_n_out);

    assert_rts_low_mark_R3: assert property (@(posedge clk) disable iff (rst)
        (feat_reg[6] && rx_level <= 6'd16) |=> !rts_n_out);

    assert_manual_rts_R4: assert property (@(posedge clk) disable iff (rst)
        !feat_reg[6] |=> (rts_n_out == !$past(mcr_rts)));

    assert_cts_bypass_R7: assert property (@(posedge clk) disable iff (rst)
        !feat_reg[7] |-> (tx_go == tx_start_req));

    assert_no_spurious_start_R8: assert property (@(posedge clk) disable iff (rst)
        tx_go |-> tx_start_req);

    assert_rts_edge_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (rts_n_out != $past(rts_n_out)) |=> rts_chg);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_en[7:6] == 2'b00) |-> !irq);
endmodule

bind uart_autoflow uart_autoflow_checker u_checker (
    .clk          (clk),
    .rst          (rst),
    .feat_reg     (feat_reg),
    .irq_en       (irq_en),
    .mcr_rts      (mcr_rts),
    .rx_level     (rx_level),
    .tx_start_req (tx_start_req),
    .rts_n_out    (rts_n_out),
    .tx_go        (tx_go),
    .rts_chg      (rts_chg),
    .irq          (irq)
);

// File: tb/uart_autoflow_test.sv
module uart_autoflow_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] feat_reg = 8'h00;
    logic [7:0] irq_en = 8'h00;
    logic       mcr_rts = 1'b0;
    logic [5:0] rx_level = 6'd0;
    logic       cts_n_in = 1'b1;
    logic       tx_start_req = 1'b0;
    logic       flag_rd = 1'b0;
    logic       rts_n_out, tx_go, rts_chg, cts_chg, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    logic m_thr, m_rts, m_rts_prev, m_s1, m_s2, m_s2_prev, m_rchg, m_cchg;

    always #5 clk = ~clk;

    uart_autoflow uut (
        .clk(clk), .rst(rst), .feat_reg(feat_reg), .irq_en(irq_en),
        .mcr_rts(mcr_rts), .rx_level(rx_level), .cts_n_in(cts_n_in),
        .tx_start_req(tx_start_req), .flag_rd(flag_rd),
        .rts_n_out(rts_n_out), .tx_go(tx_go), .rts_chg(rts_chg),
        .cts_chg(cts_chg), .irq(irq)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_tx_go();
        return tx_start_req & (~feat_reg[7] | ~m_s2);
    endfunction

    function automatic logic exp_irq();
        return (m_rchg & irq_en[6]) | (m_cchg & irq_en[7]);
    endfunction

    task automatic model_reset();
        m_thr = 0; m_rts = 1; m_rts_prev = 1;
        m_s1 = 1; m_s2 = 1; m_s2_prev = 1; m_rchg = 0; m_cchg = 0;
    endtask

    // advance the model by one clock edge with the present inputs
    task automatic model_step();
        logic thr_n, rts_n, rchg_n, cchg_n;
        if (feat_reg[6]) begin
            if (rx_level >= 6'd28) thr_n = 1;
            else if (rx_level <= 6'd16) thr_n = 0;
            else thr_n = m_thr;
            rts_n = thr_n;
        end else begin
            thr_n = 0;
            rts_n = ~mcr_rts;
        end
        rchg_n = (m_rts != m_rts_prev) ? 1'b1 : (flag_rd ? 1'b0 : m_rchg);
        cchg_n = (m_s2 != m_s2_prev) ? 1'b1 : (flag_rd ? 1'b0 : m_cchg);
        m_rts_prev = m_rts; m_s2_prev = m_s2;
        m_s2 = m_s1; m_s1 = cts_n_in;
        m_thr = thr_n; m_rts = rts_n;
        m_rchg = rchg_n; m_cchg = cchg_n;
    endtask

    // compare all outputs; called at a negedge
    task automatic compare_all(input string ctx);
        check({ctx, (feat_reg[6] ? " R3 rts" : " R4 rts")}, rts_n_out, m_rts);
        check({ctx, (feat_reg[7] ? " R6 tx_go" : " R7 tx_go")}, tx_go, exp_tx_go());
        if (!tx_start_req) check({ctx, " R8 tx_go idle"}, tx_go, 1'b0);
        check({ctx, " R9 rts_chg"}, rts_chg, m_rchg);
        check({ctx, " R9 cts_chg"}, cts_chg, m_cchg);
        check({ctx, " R10 irq"}, irq, exp_irq());
    endtask

    // one cycle: inputs already set, clock edge, then compare at negedge
    task automatic cycle(input string ctx);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all(ctx);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rts in reset", rts_n_out, 1'b1);
        check("R1 rts_chg in reset", rts_chg, 1'b0);
        check("R1 cts_chg in reset", cts_chg, 1'b0);
        check("R1 irq in reset", irq, 1'b0);
        rst = 1'b0;
        irq_en = 8'hC0;
        cycle("R1 first cycle");
        check("R1 rts after reset", rts_n_out, 1'b1);

        // R2 / R3 hysteresis ramp
        feat_reg = 8'h40;
        for (int l = 0; l <= 32; l++) begin
            rx_level = 6'(l);
            cycle("R2 ramp up");
            if (l == 27) check("R2 below mark", rts_n_out, 1'b0);
            if (l == 28) check("R2 at mark", rts_n_out, 1'b1);
        end
        for (int l = 32; l >= 0; l--) begin
            rx_level = 6'(l);
            cycle("R3 ramp down");
            if (l == 17) check("R3 band hold", rts_n_out, 1'b1);
            if (l == 16) check("R3 release", rts_n_out, 1'b0);
        end
        flag_rd = 1; cycle("R9 clear"); flag_rd = 0;

        // R3 enable from mid-band restarts released; R4 manual mode
        rx_level = 6'd30; cycle("R2 fill");
        feat_reg = 8'h00; mcr_rts = 1; rx_level = 6'd22; cycle("R4 manual");
        check("R4 manual follows mcr", rts_n_out, 1'b0);
        feat_reg = 8'h40; cycle("R3 re-enable");
        check("R3 re-enable mid band", rts_n_out, 1'b0);

        // R5 synchroniser latency and R6 gating
        feat_reg = 8'h80; tx_start_req = 1; cts_n_in = 0;
        cycle("R5 stage1");
        check("R5 not yet through", tx_go, 1'b0);
        cycle("R5 stage2");
        check("R5 through after two edges", tx_go, 1'b1);
        cts_n_in = 1;
        cycle("R6 a"); cycle("R6 b");
        check("R6 blocked", tx_go, 1'b0);
        feat_reg = 8'h00; #1;
        check("R7 bypass", tx_go, 1'b1);

        // R9 read coincident with a new edge keeps flag set
        flag_rd = 1; cycle("R9 clear2"); flag_rd = 0; cycle("R9 idle");
        cts_n_in = 0; cycle("R9 e1"); cycle("R9 e2");
        flag_rd = 1; cycle("R9 same-edge read");
        check("R9 set beats clear", cts_chg, 1'b1);
        cycle("R9 read clears"); flag_rd = 0;
        check("R9 cleared", cts_chg, 1'b0);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            feat_reg = {$urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0, 6'b0};
            irq_en = {$urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 6'b0};
            mcr_rts = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 3) == 0) rx_level = 6'($urandom_range(0, 32));
            else rx_level = 6'($urandom_range(14, 30));
            if ($urandom_range(0, 4) == 0) cts_n_in = ~cts_n_in;
            tx_start_req = $urandom_range(0, 1) == 1;
            flag_rd = $urandom_range(0, 5) == 0;
            cycle("random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule